// File: doc/BRIEF.md
# Micro-op Dispatch Arbiter with Port Legality

This block sits at the output of a small reservation station. Each of its slots holds one waiting micro-operation, described by a valid flag, a ready flag, a sequence number and an operation class. In every cycle the arbiter looks at the slots that are both valid and ready and picks at most one of them for each of five execution ports. For each port it reports a grant and the index of the chosen slot. A granted slot is released at the next clock edge.

The ports are not interchangeable. Port 0 carries either the floating-point unit or the full-function integer unit, and it serves one of them per cycle. Port 1 carries a reduced integer unit. Ports 2, 3 and 4 each serve one memory-side class. Simple integer work may use port 0 or port 1. Port 1 is filled first, and port 0 then takes the oldest remaining candidate it is allowed to run. A single slot is never handed to two ports.

The upstream stage writes slots through a one-cycle write strobe that names the slot, the class and the initial ready state. A separate wake vector later marks slots as ready. The block numbers each accepted write from a wrapping counter. Within a port, the candidate with the largest distance behind that counter is the oldest. To keep these distances unique, the block refuses new writes while the counter has caught up with a slot that is still waiting.

Top module: `uop_dispatch`

## Requirements
- R1: After reset no slot is valid, `gnt_vld` is 0 and `alloc_ready` is 1. A slot that was written before reset is never granted after it.
- R2: A write (`alloc_en`=1) is accepted only when the named slot is not valid and `alloc_ready` is 1. A write to a slot that is already valid leaves that slot's class and ready state unchanged.
- R3: A slot whose ready flag is clear is never granted. Setting its bit in `wake` makes it eligible from the cycle after that edge.
- R4: Class codes are 0 simple integer, 1 complex integer (shift, multiply, divide, address computation), 2 floating-point, 3 load, 4 store-address and 5 store-data. Port 2 grants only class 3, port 3 only class 4 and port 4 only class 5.
- R5: Port 1 grants only class 0.
- R6: Port 0 grants only classes 0, 1 and 2, and at most one slot per cycle. A floating-point op and a complex integer op therefore go out in separate cycles.
- R7: Among the candidates a port may take, the one written earliest is granted.
- R8: Port 1 takes the oldest ready simple op. Port 0 then takes the oldest of its remaining candidates, which may be the second-oldest simple op.
- R9: No slot index is granted on two ports in the same cycle.
- R10: A slot granted in a cycle is invalid after the next edge, so it is granted exactly once. It can then be written again.
- R11: The sequence counter is log2(ENTRIES)+2 bits wide. It wraps after 4*ENTRIES accepted writes, which is 32 with the defaults. While a valid slot holds the current counter value, `alloc_ready` is 0 and writes are dropped. The flag returns to 1 once that slot is granted and released.
- R12: When a simple, a floating-point, a load, a store-address and a store-data op are all ready, all five ports grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Write strobe for one slot |
| alloc_slot | input | log2(ENTRIES) | Slot to write |
| alloc_cls | input | 3 | Class code of the written op |
| alloc_rdy | input | 1 | Initial ready state of the written op |
| alloc_ready | output | 1 | Writes are currently accepted |
| wake | input | ENTRIES | Per-slot ready set |
| gnt_vld | output | 5 | Grant per port, bit p is port p |
| gnt_idx | output | 5*log2(ENTRIES) | Granted slot per port, port p at bits [p*W +: W] |

## Verification
The checker watches every cycle for the following:
- each granted slot is valid and ready;
- each port's grant respects its class legality;
- no slot index appears on two ports at once;
- every granted slot is released at the following edge.

Other behaviour can only be shown by the bench's scenarios:
- oldest-first choice within a port;
- port 1 being filled before port 0;
- port 0 alternating between the floating-point and integer units over successive cycles;
- the write stall at counter wrap;
- writes to an occupied slot being dropped.

// File: rtl/uop_dispatch.sv
module uop_dispatch #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int SEQ_W = IDX_W + 2,
  localparam int NPORT = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [IDX_W-1:0]         alloc_slot,
  input  logic [2:0]               alloc_cls,
  input  logic                     alloc_rdy,
  output logic                     alloc_ready,
  input  logic [ENTRIES-1:0]       wake,
  output logic [NPORT-1:0]         gnt_vld,
  output logic [NPORT*IDX_W-1:0]   gnt_idx
);

  localparam logic [2:0] C_SIMPLE = 3'd0, C_COMPLEX = 3'd1, C_FP = 3'd2,
                         C_LOAD = 3'd3, C_STA = 3'd4, C_STD = 3'd5;

  logic [ENTRIES-1:0]            ent_vld, ent_rdy;
  logic [ENTRIES-1:0][2:0]       ent_cls;
  logic [ENTRIES-1:0][SEQ_W-1:0] ent_seq, key;
  logic [SEQ_W-1:0]              seq_cnt;
  logic                          seq_clash, alloc_take;
  logic [NPORT-1:0][ENTRIES-1:0] cand;
  logic [NPORT-1:0][IDX_W:0]     pick_r;
  logic [ENTRIES-1:0]            p1_mask, free_mask;

  function automatic logic [IDX_W:0] pick_oldest(input logic [ENTRIES-1:0] m,
                                                 input logic [ENTRIES-1:0][SEQ_W-1:0] k);
    logic             found;
    logic [IDX_W-1:0] best;
    logic [SEQ_W-1:0] bk;
    found = 1'b0;
    best  = '0;
    bk    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (m[i] && (!found || k[i] > bk)) begin
        found = 1'b1;
        best  = IDX_W'(i);
        bk    = k[i];
      end
    end
    return {found, best};
  endfunction

  always_comb begin
    seq_clash = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      key[i] = seq_cnt - SEQ_W'(1) - ent_seq[i];
      if (ent_vld[i] && ent_seq[i] == seq_cnt) seq_clash = 1'b1;
    end
  end

  assign alloc_ready = !seq_clash;
  assign alloc_take  = alloc_en && alloc_ready && !ent_vld[alloc_slot];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      cand[0][i] = ent_vld[i] && ent_rdy[i] &&
                   (ent_cls[i] == C_SIMPLE || ent_cls[i] == C_COMPLEX || ent_cls[i] == C_FP);
      cand[1][i] = ent_vld[i] && ent_rdy[i] && ent_cls[i] == C_SIMPLE;
      cand[2][i] = ent_vld[i] && ent_rdy[i] && ent_cls[i] == C_LOAD;
      cand[3][i] = ent_vld[i] && ent_rdy[i] && ent_cls[i] == C_STA;
      cand[4][i] = ent_vld[i] && ent_rdy[i] && ent_cls[i] == C_STD;
    end
    pick_r[1] = pick_oldest(cand[1], key);
    p1_mask   = pick_r[1][IDX_W] ? (ENTRIES'(1) << pick_r[1][IDX_W-1:0]) : '0;
    pick_r[0] = pick_oldest(cand[0] & ~p1_mask, key);
    pick_r[2] = pick_oldest(cand[2], key);
    pick_r[3] = pick_oldest(cand[3], key);
    pick_r[4] = pick_oldest(cand[4], key);
    free_mask = '0;
    for (int p = 0; p < NPORT; p++) begin
      gnt_vld[p]                 = pick_r[p][IDX_W];
      gnt_idx[p*IDX_W +: IDX_W]  = pick_r[p][IDX_W-1:0];
      if (pick_r[p][IDX_W]) free_mask = free_mask | (ENTRIES'(1) << pick_r[p][IDX_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_rdy <= '0;
      ent_cls <= '0;
      ent_seq <= '0;
      seq_cnt <= '0;
    end else begin
      ent_vld <= ent_vld & ~free_mask;
      ent_rdy <= ent_rdy | wake;
      if (alloc_take) begin
        ent_vld[alloc_slot] <= 1'b1;
        ent_rdy[alloc_slot] <= alloc_rdy | wake[alloc_slot];
        ent_cls[alloc_slot] <= alloc_cls;
        ent_seq[alloc_slot] <= seq_cnt;
        seq_cnt             <= seq_cnt + SEQ_W'(1);
      end
    end
  end

endmodule

// File: rtl/uop_dispatch_chk.sv
module uop_dispatch_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [4:0]               gnt_vld,
  input logic [5*IDX_W-1:0]       gnt_idx,
  input logic [ENTRIES-1:0]       ent_vld,
  input logic [ENTRIES-1:0]       ent_rdy,
  input logic [ENTRIES-1:0][2:0]  ent_cls
);

  logic [4:0][IDX_W-1:0] ix;
  for (genvar p = 0; p < 5; p++) begin : g_port
    assign ix[p] = gnt_idx[p*IDX_W +: IDX_W];

    a_r3_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[p] |-> (ent_vld[ix[p]] && ent_rdy[ix[p]]));

    a_r10_freed: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[p] |=> !ent_vld[$past(ix[p])]);

    for (genvar q = p + 1; q < 5; q++) begin : g_pair
      a_r9_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld[p] && gnt_vld[q]) |-> (ix[p] != ix[q]));
    end
  end

  a_r6_port0_class: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> (ent_cls[ix[0]] <= 3'd2));

  a_r5_port1_simple: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> (ent_cls[ix[1]] == 3'd0));

  a_r4_port2_load: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[2] |-> (ent_cls[ix[2]] == 3'd3));

  a_r4_port3_sta: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[3] |-> (ent_cls[ix[3]] == 3'd4));

  a_r4_port4_std: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[4] |-> (ent_cls[ix[4]] == 3'd5));

endmodule

bind uop_dispatch uop_dispatch_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
  .ent_vld(ent_vld), .ent_rdy(ent_rdy), .ent_cls(ent_cls)
);

// File: tb/test_uop_dispatch.sv
`timescale 1ns/1ps
module test_uop_dispatch;
  localparam int ENTRIES = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_en = 1'b0, alloc_rdy = 1'b0;
  logic [IW-1:0] alloc_slot = '0;
  logic [2:0] alloc_cls = '0;
  logic alloc_ready;
  logic [ENTRIES-1:0] wake = '0;
  logic [4:0] gnt_vld;
  logic [5*IW-1:0] gnt_idx;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uop_dispatch #(.ENTRIES(ENTRIES)) i_uop_dispatch (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_slot(alloc_slot),
    .alloc_cls(alloc_cls), .alloc_rdy(alloc_rdy), .alloc_ready(alloc_ready),
    .wake(wake), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx));

  localparam logic [2:0] SIM = 3'd0, CPX = 3'd1, FPO = 3'd2, LD = 3'd3, STA = 3'd4, STD = 3'd5;

  // {slot, class, expected port}
  localparam logic [8:0] VEC [6] = '{
    {3'd0, SIM, 3'd1}, {3'd3, CPX, 3'd0}, {3'd7, FPO, 3'd0},
    {3'd2, LD,  3'd2}, {3'd5, STA, 3'd3}, {3'd6, STD, 3'd4}};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_g(input string tag, input logic [4:0] v,
                       input int i0, input int i1, input int i2, input int i3, input int i4);
    int want [5];
    want = '{i0, i1, i2, i3, i4};
    chk({tag, " grant mask"}, int'(gnt_vld), int'(v));
    for (int p = 0; p < 5; p++)
      if (v[p]) chk($sformatf("%s port%0d index", tag, p), int'(gnt_idx[p*IW +: IW]), want[p]);
  endtask

  task automatic alloc(input int slot, input logic [2:0] cls, input logic rdy);
    alloc_en = 1'b1; alloc_slot = IW'(slot); alloc_cls = cls; alloc_rdy = rdy;
    step();
    alloc_en = 1'b0; alloc_rdy = 1'b0;
  endtask

  task automatic wake_m(input logic [ENTRIES-1:0] m);
    wake = m;
    step();
    wake = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 grants after reset", int'(gnt_vld), 0);
    chk("R1 alloc_ready after reset", int'(alloc_ready), 1);

    // R4 R5 R6 R10: one ready op per class goes to its port, then is released
    foreach (VEC[k]) begin
      alloc(int'(VEC[k][8:6]), VEC[k][5:3], 1'b1);
      exp_g("R4/R5/R6 class routing", 5'(1) << VEC[k][2:0],
            int'(VEC[k][8:6]), int'(VEC[k][8:6]), int'(VEC[k][8:6]),
            int'(VEC[k][8:6]), int'(VEC[k][8:6]));
      step();
      chk("R10 granted slot released", int'(gnt_vld), 0);
    end

    // R3: not-ready op waits until woken
    alloc(6, CPX, 1'b0);
    step(); step();
    chk("R3 not-ready op held", int'(gnt_vld), 0);
    wake_m(8'h40);
    exp_g("R3 woken op granted", 5'b00001, 6, 0, 0, 0, 0);
    step();

    // R7 R8: simple ops fill port1 then port0, ordering by age
    alloc(5, SIM, 1'b0);
    alloc(2, SIM, 1'b0);
    alloc(7, FPO, 1'b0);
    alloc(1, CPX, 1'b0);
    wake_m(8'hA6);
    exp_g("R8 port1 oldest simple, port0 next simple", 5'b00011, 2, 5, 0, 0, 0);
    step();
    exp_g("R7 port0 older fp before complex", 5'b00001, 7, 0, 0, 0, 0);
    step();
    exp_g("R6 complex after fp on shared port", 5'b00001, 1, 0, 0, 0, 0);
    step();
    chk("R10 all released", int'(gnt_vld), 0);

    // R7 on a memory port
    alloc(3, LD, 1'b0);
    alloc(0, LD, 1'b0);
    wake_m(8'h09);
    exp_g("R7 older load first", 5'b00100, 0, 0, 3, 0, 0);
    step();
    exp_g("R7 younger load next", 5'b00100, 0, 0, 0, 0, 0);
    step();

    // R6: fp written first, complex second; one per cycle on port 0
    alloc(4, FPO, 1'b0);
    alloc(0, CPX, 1'b0);
    wake_m(8'h11);
    exp_g("R6 one op on port0 (fp)", 5'b00001, 4, 0, 0, 0, 0);
    step();
    exp_g("R6 one op on port0 (complex)", 5'b00001, 0, 0, 0, 0, 0);
    step();

    // R2: write to occupied slot is dropped
    alloc(4, SIM, 1'b0);
    alloc(4, LD, 1'b1);
    chk("R2 occupied-slot write dropped", int'(gnt_vld), 0);
    wake_m(8'h10);
    exp_g("R2 original class kept", 5'b00010, 0, 4, 0, 0, 0);
    step();

    // R12 R9: all five ports at once
    alloc(0, SIM, 1'b0);
    alloc(1, FPO, 1'b0);
    alloc(2, LD, 1'b0);
    alloc(3, STA, 1'b0);
    alloc(4, STD, 1'b0);
    wake_m(8'h1F);
    exp_g("R12 R9 five distinct grants", 5'b11111, 1, 0, 2, 3, 4);
    step();
    chk("R10 five released", int'(gnt_vld), 0);

    // R1: reset drops a waiting op
    alloc(2, LD, 1'b0);
    do_reset();
    chk("R1 alloc_ready after mid reset", int'(alloc_ready), 1);
    wake_m(8'h04);
    chk("R1 pre-reset op not granted", int'(gnt_vld), 0);

    // R11: counter catches a waiting op
    do_reset();
    alloc(0, SIM, 1'b0);
    for (int k = 0; k < 31; k++) begin
      alloc(1, LD, 1'b1);
      step();
    end
    chk("R11 alloc_ready low at wrap", int'(alloc_ready), 0);
    alloc(2, LD, 1'b1);
    chk("R11 write dropped while stalled", int'(gnt_vld), 0);
    wake_m(8'h01);
    exp_g("R11 stalled oldest op granted", 5'b00010, 0, 0, 0, 0, 0);
    step();
    chk("R11 alloc_ready restored", int'(alloc_ready), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule